// File: doc/BRIEF.md
# Multi-core shared 64-bit comparator timer

This block is a memory-mapped timer. A single free-running 64-bit up-counter is shared by several processor cores, and each core has its own comparator bank. A bank holds a 64-bit compare value, a 32-bit auto-increment step, three enable bits, a sticky event flag and one interrupt line. A core-index input on the 32-bit register port picks which bank an access reaches. The counter advances once per clock while the shared run bit is set, so no prescaler is present. Each half of the counter can be written. Both halves are read live from the counter, and software gets a consistent value by reading the high half, then the low half, then the high half again.

A bank fires when the counter is greater than or equal to its compare value, not only when the two are equal. With auto-increment on, every event adds the step to the compare value, which gives periodic events. Each bank contains a small state machine. OFF means the comparator is disabled. ARMED means it is enabled and waiting for the counter to reach the compare value. LATCHED means it is enabled, the counter is still at or above the compare value, and no auto-increment is pending. The transitions are as follows. ARM (OFF→ARMED) occurs on a control write with the comparator bit set. DISARM (any state→OFF) occurs on a control write with that bit clear. REACH (ARMED→LATCHED) occurs on a match without auto-increment. RELOAD (ARMED or LATCHED→ARMED) occurs on a match with auto-increment. REWRITE (LATCHED→ARMED) occurs on a compare-value write or when the counter drops below the compare value. The comparator-enable control bit reads back as "state is not OFF".

Top module: `banked_cmp_timer`

## Requirements
- R1: After reset, every register of every bank and the counter read as zero, and all interrupt lines are low.
- R2: While control bit 0 is 1, the counter increases by exactly one per clock. While it is 0, the counter holds its value.
- R3: The counter low half reads at 0x00 and the high half at 0x04. Both are read combinationally from the live counter, and a carry from the low half reaches the high half on the same clock.
- R4: A write to 0x00 or 0x04 replaces only that half of the counter and leaves the other half unchanged.
- R5: The control register is at 0x08. Bit 0 (run) is one value shared by all cores. Bits 1 (comparator enable), 2 (interrupt enable) and 3 (auto-increment) are held separately for the core chosen by the core index.
- R6: While its comparator is enabled, a bank sets its event flag on the clock edge after any cycle in which the counter is greater than or equal to its compare value (low half at 0x10, high half at 0x14). The edge that arms the comparator does not itself set the flag.
- R7: The event flag is bit 0 at 0x0C and is sticky. Writing 1 to it clears the flag and writing 0 has no effect. If an event and a clear happen in the same cycle, the flag stays set.
- R8: A core's interrupt line is high exactly when that core's event flag and interrupt-enable bit are both 1.
- R9: When auto-increment is enabled, each event adds the 32-bit step at 0x18 to the 64-bit compare value. The flag keeps firing until the compare value exceeds the counter.
- R10: A write to a compare value while the comparator is disabled never sets the flag, and accesses to one core's bank leave every other bank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter steps on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 5 | Byte offset of the register |
| reg_core | input | CORE_W (2) | Core index selecting the bank |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr/reg_core |
| irq | output | NUM_CORES (4) | Per-core interrupt lines |

## Verification
Reads are combinational, so a read reflects the state after the most recent edge in the same cycle. A write becomes visible one edge after it is presented. The counter first advances on the edge after the edge that writes the run bit. An event flag appears one edge after the first cycle in which an armed bank sees the counter at or above its compare value. When the bank is armed against a counter that already matches, this is two edges after the arming write is presented. The bench drives every access on the falling edge and samples on a later falling edge, after counting the intervening rising edges. When a check needs an exact count, it stops the counter, and the random auto-increment trials wait more edges than their longest possible chain of reloads before they compare the final compare value against a bench model.

// File: rtl/bct_pkg.sv
package bct_pkg;
    localparam logic [4:0] A_CNT_LO = 5'h00;
    localparam logic [4:0] A_CNT_HI = 5'h04;
    localparam logic [4:0] A_CTRL   = 5'h08;
    localparam logic [4:0] A_STAT   = 5'h0C;
    localparam logic [4:0] A_CMP_LO = 5'h10;
    localparam logic [4:0] A_CMP_HI = 5'h14;
    localparam logic [4:0] A_STEP   = 5'h18;

    localparam int CB_RUN  = 0;
    localparam int CB_CMP  = 1;
    localparam int CB_IEN  = 2;
    localparam int CB_AUTO = 3;

    typedef enum logic [1:0] {
        ST_OFF     = 2'd0,
        ST_ARMED   = 2'd1,
        ST_LATCHED = 2'd2
    } cmp_state_e;
endpackage

// File: rtl/bct_counter.sv
module bct_counter #(
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            wr_lo,
    input  logic            wr_hi,
    input  logic [DW-1:0]   wdata,
    output logic [2*DW-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (wr_lo || wr_hi) begin
            // a software write takes precedence over the increment
            if (wr_lo) cnt[DW-1:0]    <= wdata;
            if (wr_hi) cnt[2*DW-1:DW] <= wdata;
        end else if (run) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/bct_core_bank.sv
module bct_core_bank
    import bct_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2*DW-1:0] cnt_val,
    input  logic            wr_ctrl,
    input  logic            wr_stat,
    input  logic            wr_cmp_lo,
    input  logic            wr_cmp_hi,
    input  logic            wr_step,
    input  logic [DW-1:0]   wdata,
    output logic [2*DW-1:0] cmp_val,
    output logic [DW-1:0]   step_val,
    output logic            cen,
    output logic            ien,
    output logic            auto_en,
    output logic            flag,
    output logic            irq
);
    cmp_state_e state_q, state_d;
    logic       reached;
    logic       fire;
    logic       cmp_wr;

    assign reached = (cnt_val >= cmp_val);
    assign fire    = (state_q != ST_OFF) && reached;
    assign cmp_wr  = wr_cmp_lo || wr_cmp_hi;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (wr_ctrl && wdata[CB_CMP]) state_d = ST_ARMED;      // ARM
            end
            ST_ARMED: begin
                if (wr_ctrl && !wdata[CB_CMP]) state_d = ST_OFF;       // DISARM
                else if (fire && !auto_en)     state_d = ST_LATCHED;   // REACH
            end
            ST_LATCHED: begin
                if (wr_ctrl && !wdata[CB_CMP])  state_d = ST_OFF;      // DISARM
                else if (cmp_wr || !reached)    state_d = ST_ARMED;    // REWRITE
                else if (auto_en)               state_d = ST_ARMED;    // RELOAD
            end
            default: state_d = ST_OFF;
        endcase
    end

    // output / datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_val  <= '0;
            step_val <= '0;
            ien      <= 1'b0;
            auto_en  <= 1'b0;
            flag     <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ien     <= wdata[CB_IEN];
                auto_en <= wdata[CB_AUTO];
            end
            if (wr_step) step_val <= wdata;
            if (cmp_wr) begin
                if (wr_cmp_lo) cmp_val[DW-1:0]    <= wdata;
                if (wr_cmp_hi) cmp_val[2*DW-1:DW] <= wdata;
            end else if (fire && auto_en) begin
                cmp_val <= cmp_val + {{DW{1'b0}}, step_val};
            end
            if (fire)                      flag <= 1'b1;
            else if (wr_stat && wdata[0])  flag <= 1'b0;
        end
    end

    assign cen = (state_q != ST_OFF);
    assign irq = flag && ien;
endmodule

// File: rtl/banked_cmp_timer.sv
module banked_cmp_timer
    import bct_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int DATA_W    = 32,
    parameter int CORE_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_en,
    input  logic                 reg_we,
    input  logic [4:0]           reg_addr,
    input  logic [CORE_W-1:0]    reg_core,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    output logic [NUM_CORES-1:0] irq
);
    localparam int CNT_W = 2 * DATA_W;

    logic                 core_ok;
    logic                 wr_go;
    logic                 run_q;
    logic [CNT_W-1:0]     cnt_val;
    logic [CNT_W-1:0]     cmp_arr  [NUM_CORES];
    logic [DATA_W-1:0]    step_arr [NUM_CORES];
    logic [NUM_CORES-1:0] cen_vec, ien_vec, auto_vec, flag_vec;

    assign core_ok = (int'(reg_core) < NUM_CORES);
    assign wr_go   = reg_en && reg_we && core_ok;

    // shared run bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          run_q <= 1'b0;
        else if (wr_go && reg_addr == A_CTRL) run_q <= reg_wdata[CB_RUN];
    end

    bct_counter #(.DW(DATA_W)) i_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run_q),
        .wr_lo (wr_go && reg_addr == A_CNT_LO),
        .wr_hi (wr_go && reg_addr == A_CNT_HI),
        .wdata (reg_wdata),
        .cnt   (cnt_val)
    );

    for (genvar g = 0; g < NUM_CORES; g++) begin : g_bank
        logic hit;
        assign hit = wr_go && (int'(reg_core) == g);
        bct_core_bank #(.DW(DATA_W)) i_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .cnt_val   (cnt_val),
            .wr_ctrl   (hit && reg_addr == A_CTRL),
            .wr_stat   (hit && reg_addr == A_STAT),
            .wr_cmp_lo (hit && reg_addr == A_CMP_LO),
            .wr_cmp_hi (hit && reg_addr == A_CMP_HI),
            .wr_step   (hit && reg_addr == A_STEP),
            .wdata     (reg_wdata),
            .cmp_val   (cmp_arr[g]),
            .step_val  (step_arr[g]),
            .cen       (cen_vec[g]),
            .ien       (ien_vec[g]),
            .auto_en   (auto_vec[g]),
            .flag      (flag_vec[g]),
            .irq       (irq[g])
        );
    end

    // live read path, no holding latch on the counter halves
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CNT_LO: reg_rdata = cnt_val[DATA_W-1:0];
            A_CNT_HI: reg_rdata = cnt_val[CNT_W-1:DATA_W];
            A_CTRL: begin
                reg_rdata[CB_RUN] = run_q;
                if (core_ok) begin
                    reg_rdata[CB_CMP]  = cen_vec[reg_core];
                    reg_rdata[CB_IEN]  = ien_vec[reg_core];
                    reg_rdata[CB_AUTO] = auto_vec[reg_core];
                end
            end
            A_STAT:   if (core_ok) reg_rdata[0] = flag_vec[reg_core];
            A_CMP_LO: if (core_ok) reg_rdata = cmp_arr[reg_core][DATA_W-1:0];
            A_CMP_HI: if (core_ok) reg_rdata = cmp_arr[reg_core][CNT_W-1:DATA_W];
            A_STEP:   if (core_ok) reg_rdata = step_arr[reg_core];
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/bct_checker.sv
module bct_checker #(
    parameter int NUM_CORES = 4,
    parameter int DATA_W    = 32,
    parameter int CORE_W    = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  reg_en,
    input logic                  reg_we,
    input logic [4:0]            reg_addr,
    input logic [CORE_W-1:0]     reg_core,
    input logic [DATA_W-1:0]     reg_wdata,
    input logic                  run_q,
    input logic [2*DATA_W-1:0]   cnt_val,
    input logic [NUM_CORES-1:0]  cen_vec,
    input logic [NUM_CORES-1:0]  ien_vec,
    input logic [NUM_CORES-1:0]  flag_vec,
    input logic [NUM_CORES-1:0]  irq
);
    logic cnt_wr;
    assign cnt_wr = reg_en && reg_we && (reg_addr == 5'h00 || reg_addr == 5'h04);

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        run_q && !cnt_wr |=> cnt_val == $past(cnt_val) + 1'b1); // R2
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q && !cnt_wr |=> $stable(cnt_val)); // R2
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (irq & ~flag_vec) == '0); // R8
    AST_IRQ_NEEDS_IEN: assert property (@(posedge clk) disable iff (!rst_n)
        (irq & ~ien_vec) == '0); // R8

    for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
        logic clr;
        assign clr = reg_en && reg_we && reg_addr == 5'h0C
                     && int'(reg_core) == g && reg_wdata[0];
        AST_FLAG_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag_vec[g]) |-> $past(cen_vec[g])); // R10
        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            flag_vec[g] && !clr |=> flag_vec[g]); // R7
    end
endmodule

bind banked_cmp_timer bct_checker #(
    .NUM_CORES (NUM_CORES),
    .DATA_W    (DATA_W),
    .CORE_W    (CORE_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_en    (reg_en),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_core  (reg_core),
    .reg_wdata (reg_wdata),
    .run_q     (run_q),
    .cnt_val   (cnt_val),
    .cen_vec   (cen_vec),
    .ien_vec   (ien_vec),
    .flag_vec  (flag_vec),
    .irq       (irq)
);

// File: tb/test_banked_cmp_timer.sv
module test_banked_cmp_timer;
    localparam int NC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_en = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [1:0]  reg_core = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [NC-1:0] irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    banked_cmp_timer #(.NUM_CORES(NC)) i_banked_cmp_timer (
        .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_core(reg_core), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // called on a falling edge; returns on the falling edge after the write edge
    task automatic wr(int core, logic [4:0] a, logic [31:0] d);
        reg_core = 2'(core); reg_addr = a; reg_wdata = d;
        reg_en = 1'b1; reg_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0;
    endtask

    task automatic rd(int core, logic [4:0] a, output logic [31:0] d);
        reg_core = 2'(core); reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] model_cmp(logic [31:0] v, logic [31:0] c, logic [31:0] s);
        logic [31:0] r = c;
        for (int k = 0; k < 200 && r <= v; k++) r = r + s;
        return r;
    endfunction

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, d2;
        logic [31:0] v, c, s;
        int core;
        void'($urandom(32'd2024));
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1 reset state
        rd(0, 5'h08, d); chk("R1 ctrl", d, 0);
        rd(2, 5'h00, d); chk("R1 cnt lo", d, 0);
        rd(3, 5'h10, d); chk("R1 cmp", d, 0);
        chk("R1 irq", irq, 0);

        // R2 held while stopped, then one per clock
        tick(5); rd(0, 5'h00, d); chk("R2 hold", d, 0);
        wr(0, 5'h08, 32'h1);
        tick(10); rd(0, 5'h00, d); chk("R2 step", d, 10);
        // R3 live read of the low half
        tick(1); rd(0, 5'h00, d2); chk("R3 live lo", d2, 11);
        // R5 shared run bit seen through another core
        rd(1, 5'h08, d); chk("R5 shared run", d, 1);
        wr(0, 5'h08, 32'h0);
        rd(0, 5'h00, d); tick(5); rd(0, 5'h00, d2); chk("R2 stop", d2, d);

        // R4 half writes, R3 carry
        wr(0, 5'h00, 32'hFFFF_FFFF);
        wr(0, 5'h04, 32'h5);
        rd(0, 5'h00, d); chk("R4 lo", d, 32'hFFFF_FFFF);
        rd(0, 5'h04, d); chk("R4 hi", d, 5);
        wr(2, 5'h08, 32'h1);
        tick(1);
        rd(0, 5'h04, d); chk("R3 carry hi", d, 6);
        rd(0, 5'h00, d); chk("R3 carry lo", d, 0);
        wr(0, 5'h08, 32'h0);

        // R6 greater-or-equal match
        wr(0, 5'h04, 32'h0);
        wr(0, 5'h00, 32'd100);
        wr(1, 5'h10, 32'd50);
        rd(1, 5'h0C, d); chk("R10 cmp write disarmed", d, 0);
        wr(1, 5'h08, 32'h6);
        rd(1, 5'h0C, d); chk("R6 arm edge no fire", d, 0);
        tick(1);
        rd(1, 5'h0C, d); chk("R6 ge fire", d, 1);
        chk("R8 irq on", irq, 4'b0010);
        rd(1, 5'h08, d); chk("R5 banked ctrl", d, 6);
        rd(0, 5'h08, d); chk("R5 other bank", d, 0);

        // R7 sticky flag
        wr(1, 5'h0C, 32'h0); rd(1, 5'h0C, d); chk("R7 write0", d, 1);
        wr(1, 5'h0C, 32'h1); rd(1, 5'h0C, d); chk("R7 set wins", d, 1);
        wr(1, 5'h08, 32'h2);
        chk("R8 ien off", irq, 0);
        wr(1, 5'h08, 32'h0);
        wr(1, 5'h0C, 32'h1); rd(1, 5'h0C, d); chk("R7 clear", d, 0);

        // R6 below then equal
        wr(1, 5'h10, 32'd200);
        wr(1, 5'h08, 32'h2);
        tick(3); rd(1, 5'h0C, d); chk("R6 below", d, 0);
        wr(0, 5'h00, 32'd200);
        rd(1, 5'h0C, d); chk("R6 not yet", d, 0);
        tick(1); rd(1, 5'h0C, d); chk("R6 equal", d, 1);

        // R9 directed auto-increment
        wr(0, 5'h00, 32'd20);
        wr(3, 5'h10, 32'd10);
        wr(3, 5'h18, 32'd4);
        wr(3, 5'h08, 32'hA);
        tick(5);
        rd(3, 5'h10, d); chk("R9 reload", d, 22);
        rd(3, 5'h0C, d); chk("R9 flag", d, 1);

        // R10 banks independent
        rd(0, 5'h10, d); chk("R10 core0 cmp", d, 0);
        rd(2, 5'h18, d); chk("R10 core2 step", d, 0);

        // random auto-increment trials
        for (int t = 0; t < 10; t++) begin
            core = int'($urandom_range(0, NC - 1));
            v = 1000 + $urandom_range(0, 999);
            c = $urandom_range(0, 1999);
            s = 40 + $urandom_range(0, 39);
            wr(core, 5'h08, 32'h0);
            wr(core, 5'h0C, 32'h1);
            wr(0, 5'h00, v);
            wr(core, 5'h14, 32'h0);
            wr(core, 5'h10, c);
            wr(core, 5'h18, s);
            wr(core, 5'h08, 32'hE);
            tick(60);
            rd(core, 5'h10, d); chk("R9 random cmp", d, model_cmp(v, c, s));
            rd(core, 5'h0C, d); chk("R6 random flag", d, (c <= v) ? 1 : 0);
            chk("R8 random irq", irq[core], (c <= v) ? 1 : 0);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule